// File: doc/BRIEF.md
# Programmable CRC32 Stream Engine

This block folds a stream of 32-bit data words into a 32-bit running CRC whose generator polynomial is loaded at run time. Software programs the polynomial, waits for the engine to finish building its 256-entry byte lookup table, writes a starting value into the running-result register and a word count into the count register, then sets the enable bit with the operating mode set to calculate. Data words then arrive on a valid/ready stream. Each accepted word is folded in one byte per cycle, least significant byte first, using the reflected (LSB-first) form of the CRC.

Every finished word lowers the count by one. When the count reaches zero the engine stops taking data, freezes the final CRC into a result register and sets a sticky count-expired flag. A second sticky flag records compare failures that arrive on a dedicated input. Both flags are cleared by writing ones to the status register. They reach the interrupt output only through enables, which are set and cleared at separate addresses.

Top module: `crc_stream_engine`

## Requirements
- R1: After reset the status register (address 5) reads 0 with the table-done flag (bit 2) clear, the interrupt enables (read at address 6) are 0, `s_ready` is low and `irq` is low.
- R2: A write to the polynomial register (address 4) clears table-done (status bit 2) and sets it again exactly 256 cycles after the write edge. A word is never accepted while table-done is clear.
- R3: `s_ready` is high only when the control register (address 0) has enable (bit 0) set and mode field bits [2:1] equal to 01 (calculate), table-done is set, the count is nonzero and no word is being folded in.
- R4: Each accepted word takes 4 cycles: `s_ready` stays low for 4 cycles after the accepting edge. Each byte b, least significant first, updates the CRC as crc = (crc >> 8) ^ T[(crc ^ b) & 0xFF], where T holds the reflected CRC of each byte value under the polynomial.
- R5: The count register (address 1) drops by one for each finished word. When it reaches zero, count-expired (status bit 0) is set, the final CRC is latched into the result register (address 3) and `s_ready` stays low.
- R6: Status bits 0 and 1 are cleared only by writing 1 to them at address 5. Writing 0 leaves them unchanged.
- R7: Writing 1s to address 6 sets interrupt enables and writing 0s there changes nothing. Writing 1s to address 7 clears them. `irq` is high while any status bit in [1:0] is set together with its enable bit.
- R8: A one-cycle pulse on `cmp_fail` sets compare-error (status bit 1).
- R9: A polynomial write while enable is set is ignored: table-done stays set and later words use the old polynomial.
- R10: The running-result register (address 2) takes the written seed and reads back the running CRC, which equals the result register once the block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Write address |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W | Read address |
| cfg_rdata | output | 32 | Read data (combinational) |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Engine can take a word |
| cmp_fail | input | 1 | Compare-failure event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a polynomial write that arrives while a block is enabled and must leave the built table alone. Outside this case, enable is only set after a build has finished. The stimulus enables the engine with a zero count, writes a different polynomial, and checks that table-done stays set. It then runs a random block and compares the result against the old polynomial only. The table-build latency is also measured cycle by cycle from the write edge. Random seeds, counts, words and valid gaps cover two different polynomials.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;
   localparam int REG_W  = 32;
   localparam int BYTE_W = 8;

   localparam int A_CTRL   = 0;
   localparam int A_COUNT  = 1;
   localparam int A_RUNNING = 2;
   localparam int A_RESULT = 3;
   localparam int A_POLY   = 4;
   localparam int A_STATUS = 5;
   localparam int A_IEN_SET = 6;
   localparam int A_IEN_CLR = 7;

   localparam int S_EXP = 0;
   localparam int S_CMP = 1;
   localparam int S_LUT = 2;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_CALC = 2'b01,
      MODE_CMP  = 2'b10,
      MODE_RSV  = 2'b11
   } op_mode_e;
endpackage

// File: rtl/crc_lut_table.sv
module crc_lut_table
   import crc_stream_pkg::*;
#(
   parameter int CRC_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CRC_W-1:0]     poly,
   input  logic [BYTE_W-1:0]    rd_idx,
   output logic [CRC_W-1:0]     rd_val,
   output logic                 done
);
   localparam int ENTRIES = 1 << BYTE_W;
   localparam int IDX_W   = BYTE_W;

   if (CRC_W < BYTE_W) begin : g_bad_width
      $error("crc_lut_table: CRC_W must be at least one byte");
   end

   logic [CRC_W-1:0] mem [ENTRIES];
   logic [CRC_W-1:0] poly_q;
   logic [IDX_W-1:0] idx_q;
   logic             build_q;
   logic             done_q;

   function automatic logic [CRC_W-1:0] entry_of(input logic [IDX_W-1:0] i,
                                                 input logic [CRC_W-1:0] p);
      logic [CRC_W-1:0] c;
      c = CRC_W'(i);
      for (int k = 0; k < BYTE_W; k++)
         c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
      return c;
   endfunction

   always_ff @(posedge clk) begin
      if (build_q)
         mem[idx_q] <= entry_of(idx_q, poly_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poly_q  <= '0;
         idx_q   <= '0;
         build_q <= 1'b0;
         done_q  <= 1'b0;
      end else if (start) begin
         poly_q  <= poly;
         idx_q   <= '0;
         build_q <= 1'b1;
         done_q  <= 1'b0;
      end else if (build_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == IDX_W'(ENTRIES - 1)) begin
            build_q <= 1'b0;
            done_q  <= 1'b1;
         end
      end
   end

   assign rd_val = mem[rd_idx];
   assign done   = done_q;

   AST_LUT_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(idx_q) == IDX_W'(ENTRIES - 1)); // R2
endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine
   import crc_stream_pkg::*;
#(
   parameter int CRC_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 seed_we,
   input  logic [CRC_W-1:0]     seed,
   input  logic                 accept,
   input  logic [DATA_W-1:0]    word,
   output logic [BYTE_W-1:0]    lut_idx,
   input  logic [CRC_W-1:0]     lut_val,
   output logic [CRC_W-1:0]     crc,
   output logic [CRC_W-1:0]     crc_nxt,
   output logic                 busy,
   output logic                 word_done
);
   localparam int LANES  = DATA_W / BYTE_W;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

   if ((DATA_W % BYTE_W) != 0 || LANES < 2) begin : g_bad_data
      $error("crc_word_engine: DATA_W must be a multiple of 8 and at least 16");
   end

   logic [CRC_W-1:0]  crc_q;
   logic [DATA_W-1:0] word_q;
   logic [LANE_W-1:0] lane_q;
   logic              busy_q;
   logic [BYTE_W-1:0] lanes [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = word_q[g*BYTE_W +: BYTE_W];
   end

   assign lut_idx   = crc_q[BYTE_W-1:0] ^ lanes[lane_q];
   assign crc_nxt   = (crc_q >> BYTE_W) ^ lut_val;
   assign word_done = busy_q && (lane_q == LANE_W'(LANES - 1));
   assign crc       = crc_q;
   assign busy      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q  <= '0;
         word_q <= '0;
         lane_q <= '0;
         busy_q <= 1'b0;
      end else begin
         if (seed_we)
            crc_q <= seed;
         else if (busy_q)
            crc_q <= crc_nxt;
         if (accept) begin
            word_q <= word;
            lane_q <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            lane_q <= lane_q + 1'b1;
            if (lane_q == LANE_W'(LANES - 1))
               busy_q <= 1'b0;
         end
      end
   end

   AST_NO_ACCEPT_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !accept); // R4
endmodule

// File: rtl/crc_stream_engine.sv
module crc_stream_engine
   import crc_stream_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CRC_W  = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [REG_W-1:0]   cfg_wdata,
   input  logic [ADDR_W-1:0]  cfg_raddr,
   output logic [REG_W-1:0]   cfg_rdata,
   input  logic               s_valid,
   input  logic [DATA_W-1:0]  s_data,
   output logic               s_ready,
   input  logic               cmp_fail,
   output logic               irq
);
   if (CRC_W != REG_W || CNT_W > REG_W || ADDR_W < 3) begin : g_bad_cfg
      $error("crc_stream_engine: unsupported register geometry");
   end

   logic               ctrl_en;
   op_mode_e           ctrl_mode;
   logic [CNT_W-1:0]   cnt_q;
   logic [CRC_W-1:0]   res_q;
   logic               st_exp, st_cmp;
   logic [1:0]         ien_q;

   logic wr_ctrl, wr_cnt, wr_seed, wr_poly, wr_status, wr_ien_s, wr_ien_c;
   logic lut_done, busy, word_done, accept, last_word;
   logic [BYTE_W-1:0] lut_idx;
   logic [CRC_W-1:0]  lut_val, crc_cur, crc_nxt;

   assign wr_ctrl   = cfg_we && (cfg_addr == ADDR_W'(A_CTRL));
   assign wr_cnt    = cfg_we && (cfg_addr == ADDR_W'(A_COUNT));
   assign wr_seed   = cfg_we && (cfg_addr == ADDR_W'(A_RUNNING));
   assign wr_poly   = cfg_we && (cfg_addr == ADDR_W'(A_POLY));
   assign wr_status = cfg_we && (cfg_addr == ADDR_W'(A_STATUS));
   assign wr_ien_s  = cfg_we && (cfg_addr == ADDR_W'(A_IEN_SET));
   assign wr_ien_c  = cfg_we && (cfg_addr == ADDR_W'(A_IEN_CLR));

   crc_lut_table #(.CRC_W(CRC_W)) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (wr_poly && !ctrl_en),
      .poly   (cfg_wdata[CRC_W-1:0]),
      .rd_idx (lut_idx),
      .rd_val (lut_val),
      .done   (lut_done)
   );

   crc_word_engine #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_we   (wr_seed && !busy),
      .seed      (cfg_wdata[CRC_W-1:0]),
      .accept    (accept),
      .word      (s_data),
      .lut_idx   (lut_idx),
      .lut_val   (lut_val),
      .crc       (crc_cur),
      .crc_nxt   (crc_nxt),
      .busy      (busy),
      .word_done (word_done)
   );

   assign s_ready   = ctrl_en && (ctrl_mode == MODE_CALC) && lut_done && !busy && (cnt_q != '0);
   assign accept    = s_valid && s_ready;
   assign last_word = word_done && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         ctrl_mode <= MODE_OFF;
         cnt_q     <= '0;
         res_q     <= '0;
         st_exp    <= 1'b0;
         st_cmp    <= 1'b0;
         ien_q     <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en   <= cfg_wdata[0];
            ctrl_mode <= op_mode_e'(cfg_wdata[2:1]);
         end
         if (wr_cnt)
            cnt_q <= cfg_wdata[CNT_W-1:0];
         else if (word_done && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
         if (last_word)
            res_q <= crc_nxt;
         if (last_word)
            st_exp <= 1'b1;
         else if (wr_status && cfg_wdata[S_EXP])
            st_exp <= 1'b0;
         if (cmp_fail)
            st_cmp <= 1'b1;
         else if (wr_status && cfg_wdata[S_CMP])
            st_cmp <= 1'b0;
         if (wr_ien_s)
            ien_q <= ien_q | cfg_wdata[1:0];
         else if (wr_ien_c)
            ien_q <= ien_q & ~cfg_wdata[1:0];
      end
   end

   assign irq = |({st_cmp, st_exp} & ien_q);

   always_comb begin
      cfg_rdata = '0;
      case (cfg_raddr)
         ADDR_W'(A_CTRL):    cfg_rdata = REG_W'({ctrl_mode, ctrl_en});
         ADDR_W'(A_COUNT):   cfg_rdata = REG_W'(cnt_q);
         ADDR_W'(A_RUNNING): cfg_rdata = REG_W'(crc_cur);
         ADDR_W'(A_RESULT):  cfg_rdata = REG_W'(res_q);
         ADDR_W'(A_STATUS):  cfg_rdata = REG_W'({lut_done, st_cmp, st_exp});
         ADDR_W'(A_IEN_SET): cfg_rdata = REG_W'(ien_q);
         default:            cfg_rdata = '0;
      endcase
   end

   AST_ACCEPT_NEEDS_LUT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> lut_done); // R2
   AST_EXP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_exp) |-> (cnt_q == '0) && !s_ready); // R5
   AST_EXP_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_exp) |-> $past(wr_status && cfg_wdata[S_EXP])); // R6
   AST_POLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_poly && ctrl_en && lut_done) |=> lut_done); // R9
endmodule

// File: tb/sim_crc_stream_engine.sv
`timescale 1ns/1ps
module sim_crc_stream_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [2:0]  cfg_raddr = '0;
   logic [31:0] cfg_rdata;
   logic        s_valid = 1'b0;
   logic [31:0] s_data = '0;
   logic        s_ready;
   logic        cmp_fail = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   localparam logic [31:0] POLY_A = 32'hEDB88320;
   localparam logic [31:0] POLY_B = 32'h82F63B78;

   always #2 clk = ~clk;

   crc_stream_engine u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .cmp_fail(cmp_fail), .irq(irq)
   );

   function automatic logic [31:0] gold_word(logic [31:0] c, logic [31:0] w, logic [31:0] p);
      c = c ^ w;
      for (int k = 0; k < 32; k++)
         c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
      return c;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      cfg_raddr = a;
      #0.5;
      d = cfg_rdata;
   endtask

   task automatic send_word(logic [31:0] w);
      s_valid = 1'b1; s_data = w;
      #0.5;
      while (!s_ready) begin
         @(negedge clk);
         #0.5;
      end
      @(negedge clk);
      s_valid = 1'b0;
   endtask

   task automatic build(logic [31:0] p, string req);
      logic [31:0] st;
      int k;
      wr(3'd4, p);
      rd(3'd5, st);
      check({req, " table-done cleared by poly write"}, 32'(st[2]), 32'd0);
      k = 0;
      while (!st[2] && k < 400) begin
         @(negedge clk);
         k++;
         rd(3'd5, st);
      end
      check({req, " build latency"}, 32'(k), 32'd256);
   endtask

   task automatic run_block(logic [31:0] p, int n, bit timing);
      logic [31:0] seed, exp, v;
      seed = $urandom;
      exp  = seed;
      wr(3'd2, seed);
      rd(3'd2, v);
      check("R10 seed readback", v, seed);
      wr(3'd1, 32'(n));
      wr(3'd0, 32'h3);
      for (int i = 0; i < n; i++) begin
         logic [31:0] w;
         int gap;
         w = $urandom;
         gap = $urandom_range(0, 2);
         for (int g = 0; g < gap; g++) @(negedge clk);
         send_word(w);
         exp = gold_word(exp, w, p);
         if (timing && i < n - 1) begin
            int k;
            k = 0;
            #0.5;
            while (!s_ready && k < 20) begin
               k++;
               @(negedge clk);
               #0.5;
            end
            check("R4 ready low cycles per word", 32'(k), 32'd4);
         end
      end
      repeat (5) @(negedge clk);
      rd(3'd5, v);
      check("R5 count-expired set", 32'(v[0]), 32'd1);
      rd(3'd1, v);
      check("R5 count reached zero", v, 32'd0);
      check("R5 ready low at zero", 32'(s_ready), 32'd0);
      rd(3'd3, v);
      check("R4 R5 final result", v, exp);
      rd(3'd2, v);
      check("R10 running value equals result", v, exp);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2468));
      repeat (3) @(negedge clk);
      rd(3'd5, v);
      check("R1 status after reset", v, 32'd0);
      rd(3'd6, v);
      check("R1 enables after reset", v, 32'd0);
      check("R1 ready after reset", 32'(s_ready), 32'd0);
      check("R1 irq after reset", 32'(irq), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      build(POLY_A, "R2");

      // R3: ready gating by mode, enable and count
      wr(3'd1, 32'd2);
      wr(3'd0, 32'h1);
      check("R3 ready low with mode off", 32'(s_ready), 32'd0);
      wr(3'd0, 32'h5);
      check("R3 ready low with compare mode", 32'(s_ready), 32'd0);
      wr(3'd0, 32'h2);
      check("R3 ready low with enable clear", 32'(s_ready), 32'd0);
      wr(3'd0, 32'h3);
      check("R3 ready high when all conditions met", 32'(s_ready), 32'd1);
      wr(3'd1, 32'd0);
      check("R3 ready low with zero count", 32'(s_ready), 32'd0);
      wr(3'd0, 32'h0);

      for (int b = 0; b < 6; b++) begin
         run_block(POLY_A, $urandom_range(1, 6), b < 2);
         if (b == 0) begin
            check("R7 irq low with enables clear", 32'(irq), 32'd0);
            wr(3'd6, 32'h1);
            check("R7 irq from count-expired", 32'(irq), 32'd1);
            wr(3'd6, 32'h0);
            rd(3'd6, v);
            check("R7 zero write to set-register keeps enables", v, 32'd1);
            wr(3'd5, 32'h0);
            rd(3'd5, v);
            check("R6 zero write keeps count-expired", 32'(v[0]), 32'd1);
            wr(3'd7, 32'h1);
            check("R7 irq low after enable clear", 32'(irq), 32'd0);
         end
         wr(3'd0, 32'h0);
         wr(3'd5, 32'h1);
         rd(3'd5, v);
         check("R6 one write clears count-expired", 32'(v[0]), 32'd0);
      end

      // R9: polynomial write while enabled must not rebuild
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h3);
      wr(3'd4, POLY_B);
      repeat (3) @(negedge clk);
      rd(3'd5, v);
      check("R9 table-done stays set", 32'(v[2]), 32'd1);
      run_block(POLY_A, 4, 1'b0);
      wr(3'd0, 32'h0);
      wr(3'd5, 32'h1);

      build(POLY_B, "R2 second poly");
      for (int b = 0; b < 4; b++) begin
         run_block(POLY_B, $urandom_range(1, 8), b == 0);
         wr(3'd0, 32'h0);
         wr(3'd5, 32'h1);
      end

      // R8 / R7 / R6 on compare-error
      @(negedge clk);
      cmp_fail = 1'b1;
      @(negedge clk);
      cmp_fail = 1'b0;
      rd(3'd5, v);
      check("R8 compare-error set", 32'(v[1]), 32'd1);
      check("R7 irq low while bit 1 disabled", 32'(irq), 32'd0);
      wr(3'd6, 32'h2);
      check("R7 irq from compare-error", 32'(irq), 32'd1);
      wr(3'd5, 32'h1);
      rd(3'd5, v);
      check("R6 clearing bit 0 keeps bit 1", 32'(v[1]), 32'd1);
      wr(3'd5, 32'h2);
      rd(3'd5, v);
      check("R6 compare-error cleared", 32'(v[1]), 32'd0);
      check("R7 irq drops with status", 32'(irq), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule